// File: doc/BRIEF.md
# Transmit Queue with Occupancy Flags

This block is a synchronous first-in first-out queue, 32 bits (one quadlet) wide, that sits between a host write port and the engine that sends asynchronous packets. The host pushes quadlets. The transmitter engine pops them and sees each one on a registered data output. The storage has a fixed physical maximum of 256 entries. Software may lower the usable depth at run time through a size field in a combined control and status word.

The status word reports five occupancy flags: no space left, exactly one slot left, at least four slots left, exactly one entry stored, and nothing stored. Software writes the control word through a single write strobe. The write programs the size field, and it can also request a clear that empties the queue. The clear request reads back as set for one cycle and then clears itself.

Physical entries are always addressed as a ring of the full maximum depth. The programmed size limits only the occupancy that is allowed. If the size is lowered below the current fill level, the stored data stays valid and the queue simply reports full until enough entries have been read out.

Top module: `txq_fifo`

## Requirements
- R1: After synchronous active-low reset, rd_data is 0 and status reads 0x0000_8010: empty (bit 15) and four-available (bit 4) are set, and the size field, the clear bit and all other bits are 0.
- R2: Accepted quadlets leave in the order they were written. A read accepted at a clock edge puts the oldest stored quadlet on rd_data right after that edge.
- R3: Status bit 0 (full) is set while occupancy is greater than or equal to the effective depth. A write while full is ignored unless a read is accepted at the same edge.
- R4: Status bit 1 (almost-full) is set exactly when occupancy equals effective depth minus one.
- R5: Status bit 4 (four-available) is set when occupancy does not exceed the effective depth and the effective depth minus occupancy is at least four.
- R6: Status bit 14 (almost-empty) is set exactly when one quadlet is stored. Status bit 15 (empty) is set exactly when none are stored.
- R7: A csr_we pulse loads csr_wdata[31:23] into the size field, which reads back on status[31:23]. The effective depth equals the size for values 1 to 256. It is 256 for a size of 0 or any size above 256.
- R8: A csr_we pulse with csr_wdata[19] set makes status bit 19 read 1 for exactly the next cycle. At the end of that cycle the occupancy becomes 0, and any read or write requested in that cycle is dropped.
- R9: A read while empty is ignored, and rd_data keeps its previous value.
- R10: When a read and a write arrive together while full, both are accepted and occupancy is unchanged. When they arrive together while empty, only the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write request |
| wr_data | input | 32 | Quadlet to store |
| rd_en | input | 1 | Transmitter read request |
| rd_data | output | 32 | Last quadlet read |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word: bit 19 clear, bits 31:23 size |
| status | output | 32 | Flags, clear bit and size field |

## Verification
The bench targets the edges of the occupancy range at several programmed sizes, including sizes 1 and 5, a size of 0, and a size above the maximum. A design with an off-by-one in a flag would report almost-full or four-available one entry early or late, and one that decoded the size wrongly would either stop accepting data at the wrong point or overrun the ring. It drives simultaneous reads and writes at full and at empty, where a wrong acceptance rule either loses a quadlet or changes occupancy. It also issues clears with traffic in the clear cycle; a design that let that traffic through would leave a stray entry after the clear or show stale data.

// File: rtl/txq_pkg.sv
// Shared constants for the transmit queue: data width, physical depth and
// the bit positions of the combined control/status word.
package txq_pkg;
    localparam int unsigned TXQ_DATA_W = 32;
    localparam int unsigned TXQ_MAX_DEPTH = 256;
    localparam int unsigned TXQ_SIZE_W = 9;
    localparam int unsigned TXQ_SIZE_LSB = 23;
    localparam int unsigned B_FULL = 0;
    localparam int unsigned B_AFULL = 1;
    localparam int unsigned B_FOUR = 4;
    localparam int unsigned B_AEMPTY = 14;
    localparam int unsigned B_EMPTY = 15;
    localparam int unsigned B_CLEAR = 19;

    // Flag bundle produced by the flag generator.
    typedef struct packed {
        logic full;
        logic afull;
        logic four;
        logic aempty;
        logic empty;
    } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
// Ring storage for the transmit queue. Writes land at wptr when wr_ok.
// A read (rd_ok) registers mem[rptr] onto rd_data, which otherwise holds.
// Assumes the controller only asserts wr_ok/rd_ok when legal.
module txq_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ok,
    input  logic [PTR_W-1:0]  rptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted quadlet.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_data;
        end
    end

    // Register the head entry on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= mem[rptr];
        end
    end
endmodule

// File: rtl/txq_ctrl.sv
// Pointer and occupancy controller. Decides read/write acceptance from the
// full/empty flags, advances ring pointers over the full physical depth, and
// resets pointers and count when clr_pend is high, dropping that cycle's
// traffic. Assumes full/empty come from the flag generator for this count.
module txq_ctrl #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             full,
    input  logic             empty,
    input  logic             clr_pend,
    input  logic             clr_req,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Acceptance: a read frees a slot so a write may pass while full.
    always_comb begin
        rd_ok = rd_en && !clr_pend && !empty;
        wr_ok = wr_en && !clr_pend && (!full || rd_ok);
    end

    // Pointer and count state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_pend) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clr_pend) |=> (count == $past(count)));
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> (count == '0));
    // R10
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !empty && wr_en && rd_en && !clr_pend) |=> (count == $past(count)));
    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !clr_pend) |=> (count == '0));
    // R8
    clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !clr_req) |=> !clr_pend);
endmodule

// File: rtl/txq_flags.sv
// Occupancy flag generator. Compares the count against the effective depth,
// which may be below the count after software shrinks the size.
// Assumes depth is in 1..DEPTH.
module txq_flags #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         count,
    input  logic [CNT_W-1:0]         depth,
    output txq_pkg::txq_flags_t      flags
);
    logic [CNT_W-1:0] room;

    // Derive all five flags from count and depth.
    always_comb begin
        room         = (count <= depth) ? (depth - count) : '0;
        flags.full   = (count >= depth);
        flags.afull  = (count == depth - 1'b1);
        flags.four   = (room >= CNT_W'(4));
        flags.aempty = (count == CNT_W'(1));
        flags.empty  = (count == '0);
    end

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.empty && flags.aempty));
    // R5
    four_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.four && (flags.full || flags.afull)));
endmodule

// File: rtl/txq_fifo.sv
// Transmit queue top. Holds the control fields (size, self-clearing clear
// request), derives the effective depth, and assembles the status word.
// Assumes csr_we is a single-cycle strobe addressed to this register.
module txq_fifo #(
    parameter int unsigned DATA_W = txq_pkg::TXQ_DATA_W,
    parameter int unsigned DEPTH = txq_pkg::TXQ_MAX_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
    localparam int unsigned SZ_W = txq_pkg::TXQ_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              csr_we,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       status
);
    import txq_pkg::*;

    logic [SZ_W-1:0]  size_q;
    logic             clr_pend;
    logic             clr_req;
    logic [CNT_W-1:0] depth;
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             wr_ok;
    logic             rd_ok;
    txq_flags_t       flags;

    assign clr_req = csr_we && csr_wdata[B_CLEAR];

    // Control register: size field and one-cycle clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= '0;
            clr_pend <= 1'b0;
        end else begin
            clr_pend <= clr_req;
            if (csr_we) size_q <= csr_wdata[TXQ_SIZE_LSB +: SZ_W];
        end
    end

    // Effective depth: zero or oversize selects the physical maximum.
    always_comb begin
        if (size_q == '0 || 32'(size_q) > DEPTH) depth = CNT_W'(DEPTH);
        else depth = CNT_W'(size_q);
    end

    // Assemble the status word.
    always_comb begin
        status = '0;
        status[B_FULL]   = flags.full;
        status[B_AFULL]  = flags.afull;
        status[B_FOUR]   = flags.four;
        status[B_AEMPTY] = flags.aempty;
        status[B_EMPTY]  = flags.empty;
        status[B_CLEAR]  = clr_pend;
        status[TXQ_SIZE_LSB +: SZ_W] = size_q;
    end

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .full(flags.full), .empty(flags.empty), .clr_pend(clr_pend),
        .clr_req(clr_req), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .wptr(wptr), .rptr(rptr), .count(count)
    );

    txq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(count), .depth(depth), .flags(flags)
    );

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wptr(wptr),
        .wr_data(wr_data), .rd_ok(rd_ok), .rptr(rptr), .rd_data(rd_data)
    );

    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_EMPTY] && rd_en) |=> $stable(rd_data));
    // R8
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> status[B_EMPTY]);
    // R7
    size_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (status[31:23] == $past(csr_wdata[31:23])));
endmodule

// File: tb/txq_fifo_bench.sv
module txq_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] status;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int unsigned q[$];
    bit          m_clr = 0;
    int          m_size = 0;
    int unsigned m_last = 0;

    always #5 clk = ~clk;

    txq_fifo u_txq_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .status(status)
    );

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mdepth();
        return (m_size == 0 || m_size > 256) ? 256 : m_size;
    endfunction

    // Apply one cycle of stimulus, advance the model, compare all fields.
    task automatic step(bit w, int unsigned wd, bit r, bit c, int unsigned cw);
        int d;
        int n;
        bit rok;
        bit wok;
        @(negedge clk);
        wr_en = w; wr_data = wd; rd_en = r; csr_we = c; csr_wdata = cw;
        @(posedge clk);
        d = mdepth();
        n = q.size();
        if (m_clr) begin
            q.delete();
        end else begin
            rok = r && (n != 0);
            wok = w && ((n < d) || rok);
            if (rok) m_last = q.pop_front();
            if (wok) q.push_back(wd);
        end
        m_clr = c && cw[19];
        if (c) m_size = int'(cw[31:23]);
        #1;
        d = mdepth();
        n = q.size();
        chk("R2 rd_data", rd_data, m_last);
        chk("R3 full", status[0], n >= d);
        chk("R4 almost-full", status[1], n == d - 1);
        chk("R5 four-available", status[4], (n <= d) && (d - n >= 4));
        chk("R6 almost-empty", status[14], n == 1);
        chk("R6 empty", status[15], n == 0);
        chk("R7 size field", status[31:23], m_size);
        chk("R8 clear bit", status[19], m_clr);
    endtask

    function automatic int unsigned szw(int s, bit clr);
        return (32'(s) << 23) | (clr ? 32'h0008_0000 : 32'h0);
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 status", status, 32'h0000_8010);
        chk("R1 rd_data", rd_data, 0);

        // R9 read while empty, R2 order at full depth
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < 260; i++) step(1, 32'hA000_0000 + i, 0, 0, 0); // R3 overflow ignored
        step(1, 32'hBEEF, 1, 0, 0);  // R10 pass while full
        for (int i = 0; i < 258; i++) step(0, 0, 1, 0, 0);  // drain, R9 at end
        step(1, 32'h1234, 1, 0, 0);  // R10 empty: write only
        step(0, 0, 1, 0, 0);

        // R7 size 5, fill to full and check boundary flags
        step(0, 0, 0, 1, szw(5, 0));
        for (int i = 0; i < 7; i++) step(1, 32'h5000 + i, 0, 0, 0);
        step(1, 32'h5555, 1, 0, 0);
        // shrink below occupancy
        step(0, 0, 0, 1, szw(2, 0));
        for (int i = 0; i < 4; i++) step(1, 32'h6000 + i, 1, 0, 0);
        // R8 clear with traffic in the clear cycle
        step(1, 32'h7000, 0, 1, szw(1, 1));
        step(1, 32'h7001, 1, 0, 0);
        step(1, 32'h7002, 0, 0, 0);
        step(1, 32'h7003, 0, 0, 0);  // size 1 full
        step(0, 0, 1, 0, 0);
        // R7 oversize and zero sizes
        step(0, 0, 0, 1, szw(300, 0));
        for (int i = 0; i < 258; i++) step(1, 32'h8000 + i, 0, 0, 0);
        step(0, 0, 0, 1, szw(0, 1));
        step(0, 0, 1, 0, 0);

        // mixed random traffic at several sizes
        for (int p = 0; p < 6; p++) begin
            int sz;
            sz = (p == 0) ? 1 : (p == 1) ? 4 : (p == 2) ? 5 : (p == 3) ? 17 : (p == 4) ? 0 : 511;
            step(0, 0, 0, 1, szw(sz, 1));
            for (int i = 0; i < 1500; i++) begin
                bit w;
                bit r;
                bit c;
                w = ($urandom_range(0, 99) < ((i % 400) < 200 ? 70 : 30));
                r = ($urandom_range(0, 99) < ((i % 400) < 200 ? 30 : 70));
                c = ($urandom_range(0, 199) == 0);
                step(w, $urandom, r, c, szw(sz, c));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule